// File: doc/BRIEF.md
# Packed Lane Shuffle Unit

This block rearranges the lanes of two 64-bit packed operands, called vs and vt, into one 64-bit result. It has no clock. The result follows the inputs within the same cycle. A 5-bit opcode carries two things: the element format in its low bits and the permutation in its remaining bits.

In byte format the data holds eight unsigned 8-bit lanes. In halfword format it holds four 16-bit lanes. Result lane i always occupies bits starting at 8*i in byte format and at 16*i in halfword format.

Byte ops cover three families:
- gathering the odd or even lanes of both sources;
- interleaving the upper or lower halves of the two sources;
- widening the low half of vs with a sign-fill byte placed after each byte.

Halfword ops cover four families: interleave, odd-lane pack, butterfly swap and half replication. Any opcode with no permutation assigned drives the result to zero and raises an invalid flag. The surrounding datapath supplies the operands and takes the result. Register access is outside this block.

Top module: `lane_shuffle_unit`

## Requirements
- R1: The low two opcode bits select the format. A value of 01 selects halfword format, with op index op[4:2]. A bit 0 of 0 selects byte format, with op index op[4:1]. A value of 11 is always invalid.
- R2: Byte op index 3 (opcode 6) is pack-odd: result lanes 0..3 = vt lanes 1,3,5,7 and lanes 4..7 = vs lanes 1,3,5,7. Byte op index 4 (opcode 8) is pack-even: the same arrangement using lanes 0,2,4,6.
- R3: Byte op index 5 (opcode 10) interleaves the upper halves: lanes 0..7 = vt4,vs4,vt5,vs5,vt6,vs6,vt7,vs7. Byte op index 6 (opcode 12) does the same with lanes 0..3.
- R4: Byte op index 2 (opcode 4) is the sign-filled widen: lanes 0..7 = vs0,f(vs0),vs1,f(vs1),vs2,f(vs2),vs3,f(vs3). Here f(x) is 0xFF when bit 7 of x is 1 and 0x00 otherwise.
- R5: Halfword op index 0 (opcode 1) gives lanes vt2,vs2,vt3,vs3. Halfword op index 1 (opcode 5) gives lanes vt0,vs0,vt1,vs1.
- R6: Halfword op index 2 (opcode 9) gives lanes vt1,vt3,vs1,vs3.
- R7: Halfword op index 4 (opcode 17) is the butterfly and gives lanes vt1,vs0,vt3,vs2.
- R8: Halfword op index 5 (opcode 21) gives lanes vt2,vt3,vs2,vs3. Halfword op index 6 (opcode 25) gives lanes vt0,vt1,vs0,vs1.
- R9: Any opcode whose op index has no mapping sets invalid_o to 1 and result_o to zero. These are byte indices 0, 1 and 7..15, halfword indices 3 and 7, and format 11. Every mapped opcode sets invalid_o to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Opcode: format in the low bits, op index above them |
| vs_i | input | 64 | First packed source |
| vt_i | input | 64 | Second packed source |
| result_o | output | 64 | Permuted packed result |
| invalid_o | output | 1 | High when the opcode has no mapping |

## Verification
The sign-fill lanes are the hardest to exercise: they only show a difference when the low four bytes of vs mix set and clear top bits. Those operands must also be unlike vt, so that a fill taken from the wrong source or the wrong lane changes the result. The stimulus therefore uses vs patterns whose bytes alternate between top bit set and top bit clear, in both phases. The second bit of the format field is another case that is easy to miss. It is reached by sending the opcodes that sit next to valid halfword codes but end in 11, and by sending unmapped indices in both formats.

// File: rtl/lane_shuffle_pkg.sv
// Package lane_shuffle_pkg
// Shared sizes, source selectors and lane-routing functions for the
// packed lane shuffle unit. Assumes a 64-bit datapath split into byte
// or halfword lanes; the route functions are written in terms of the
// lane count so each map is derived, not tabulated.
package lane_shuffle_pkg;

    localparam int DATA_W   = 64;
    localparam int OP_W     = 5;
    localparam int BYTE_W   = 8;
    localparam int HALF_W   = 16;
    localparam int LANES_B  = DATA_W / BYTE_W;
    localparam int LANES_H  = DATA_W / HALF_W;
    localparam int ELEM_W   = $clog2(LANES_B);
    localparam int BIDX_W   = OP_W - 1;
    localparam int HIDX_W   = OP_W - 2;

    // Byte op indices (opcode >> 1)
    localparam logic [BIDX_W-1:0] B_WIDEN_SGN = BIDX_W'(2);
    localparam logic [BIDX_W-1:0] B_PACK_ODD  = BIDX_W'(3);
    localparam logic [BIDX_W-1:0] B_PACK_EVEN = BIDX_W'(4);
    localparam logic [BIDX_W-1:0] B_MIX_UP    = BIDX_W'(5);
    localparam logic [BIDX_W-1:0] B_MIX_LO    = BIDX_W'(6);

    // Halfword op indices (opcode >> 2)
    localparam logic [HIDX_W-1:0] H_MIX_UP    = HIDX_W'(0);
    localparam logic [HIDX_W-1:0] H_MIX_LO    = HIDX_W'(1);
    localparam logic [HIDX_W-1:0] H_PACK_ODD  = HIDX_W'(2);
    localparam logic [HIDX_W-1:0] H_SWAP      = HIDX_W'(4);
    localparam logic [HIDX_W-1:0] H_REP_UP    = HIDX_W'(5);
    localparam logic [HIDX_W-1:0] H_REP_LO    = HIDX_W'(6);

    typedef enum logic [1:0] {
        FMT_BYTE = 2'd0,
        FMT_HALF = 2'd1,
        FMT_NONE = 2'd2
    } lane_fmt_e;

    typedef enum logic [1:0] {
        SRC_ZERO = 2'd0,
        SRC_VS   = 2'd1,
        SRC_VT   = 2'd2,
        SRC_FILL = 2'd3
    } lane_src_e;

    typedef struct packed {
        lane_src_e         src;
        logic [ELEM_W-1:0] elem;
    } lane_route_t;

    // Build one route entry from a selector and an integer lane number.
    function automatic lane_route_t mk_route(lane_src_e s, int e);
        lane_route_t r;
        r.src  = s;
        r.elem = ELEM_W'(e);
        return r;
    endfunction

    // Source lane for byte result lane `lane` under op index `idx`.
    function automatic lane_route_t byte_route(logic [BIDX_W-1:0] idx, int lane);
        int half;
        half = LANES_B / 2;
        case (idx)
            B_WIDEN_SGN: return mk_route((lane % 2 == 0) ? SRC_VS : SRC_FILL, lane / 2);
            B_PACK_ODD:  return (lane < half) ? mk_route(SRC_VT, 2 * lane + 1)
                                              : mk_route(SRC_VS, 2 * (lane - half) + 1);
            B_PACK_EVEN: return (lane < half) ? mk_route(SRC_VT, 2 * lane)
                                              : mk_route(SRC_VS, 2 * (lane - half));
            B_MIX_UP:    return mk_route((lane % 2 == 0) ? SRC_VT : SRC_VS, half + lane / 2);
            B_MIX_LO:    return mk_route((lane % 2 == 0) ? SRC_VT : SRC_VS, lane / 2);
            default:     return mk_route(SRC_ZERO, 0);
        endcase
    endfunction

    // Source lane for halfword result lane `lane` under op index `idx`.
    function automatic lane_route_t half_route(logic [HIDX_W-1:0] idx, int lane);
        int half;
        half = LANES_H / 2;
        case (idx)
            H_MIX_UP:   return mk_route((lane % 2 == 0) ? SRC_VT : SRC_VS, half + lane / 2);
            H_MIX_LO:   return mk_route((lane % 2 == 0) ? SRC_VT : SRC_VS, lane / 2);
            H_PACK_ODD: return (lane < half) ? mk_route(SRC_VT, 2 * lane + 1)
                                             : mk_route(SRC_VS, 2 * (lane - half) + 1);
            H_SWAP:     return (lane % 2 == 0) ? mk_route(SRC_VT, lane + 1)
                                               : mk_route(SRC_VS, lane - 1);
            H_REP_UP:   return (lane < half) ? mk_route(SRC_VT, half + lane)
                                             : mk_route(SRC_VS, lane);
            H_REP_LO:   return (lane < half) ? mk_route(SRC_VT, lane)
                                             : mk_route(SRC_VS, lane - half);
            default:    return mk_route(SRC_ZERO, 0);
        endcase
    endfunction

endpackage

// File: rtl/lane_shuffle_decode.sv
// Module lane_shuffle_decode
// Splits the opcode into a format and the two candidate op indices.
// Assumes format 01 = halfword, bit0 = 0 = byte, 11 = no format.
module lane_shuffle_decode
    import lane_shuffle_pkg::*;
(
    input  logic [OP_W-1:0]   op_i,
    output lane_fmt_e         fmt_o,
    output logic [BIDX_W-1:0] bidx_o,
    output logic [HIDX_W-1:0] hidx_o
);

    // Classify the format field.
    always_comb begin
        if (op_i[0] == 1'b0)
            fmt_o = FMT_BYTE;
        else if (op_i[1] == 1'b0)
            fmt_o = FMT_HALF;
        else
            fmt_o = FMT_NONE;
    end

    // Strip the format bits to form each op index.
    assign bidx_o = op_i[OP_W-1:1];
    assign hidx_o = op_i[OP_W-1:2];

endmodule

// File: rtl/lane_shuffle_byte.sv
// Module lane_shuffle_byte
// Byte-format permutation path: each result lane picks a vs or vt
// byte, or a sign-fill byte from vs, according to the op index.
// Assumes the caller qualifies the result with the format decode.
module lane_shuffle_byte
    import lane_shuffle_pkg::*;
(
    input  logic [BIDX_W-1:0] idx_i,
    input  logic [DATA_W-1:0] vs_i,
    input  logic [DATA_W-1:0] vt_i,
    output logic [DATA_W-1:0] res_o,
    output logic              hit_o
);

    // Report whether the op index has a byte mapping.
    always_comb begin
        case (idx_i)
            B_WIDEN_SGN, B_PACK_ODD, B_PACK_EVEN, B_MIX_UP, B_MIX_LO: hit_o = 1'b1;
            default: hit_o = 1'b0;
        endcase
    end

    for (genvar g = 0; g < LANES_B; g++) begin : g_lane
        lane_route_t       rt;
        logic [BYTE_W-1:0] vs_b;
        logic [BYTE_W-1:0] vt_b;

        // Look up the route for this lane.
        assign rt   = byte_route(idx_i, g);
        assign vs_b = vs_i[BYTE_W*rt.elem +: BYTE_W];
        assign vt_b = vt_i[BYTE_W*rt.elem +: BYTE_W];

        // Select the lane payload from the routed source.
        always_comb begin
            case (rt.src)
                SRC_VS:   res_o[BYTE_W*g +: BYTE_W] = vs_b;
                SRC_VT:   res_o[BYTE_W*g +: BYTE_W] = vt_b;
                SRC_FILL: res_o[BYTE_W*g +: BYTE_W] = {BYTE_W{vs_b[BYTE_W-1]}};
                default:  res_o[BYTE_W*g +: BYTE_W] = '0;
            endcase
        end
    end

endmodule

// File: rtl/lane_shuffle_half.sv
// Module lane_shuffle_half
// Halfword-format permutation path: each result lane picks a vs or vt
// halfword according to the op index. No fill source exists here.
module lane_shuffle_half
    import lane_shuffle_pkg::*;
(
    input  logic [HIDX_W-1:0] idx_i,
    input  logic [DATA_W-1:0] vs_i,
    input  logic [DATA_W-1:0] vt_i,
    output logic [DATA_W-1:0] res_o,
    output logic              hit_o
);

    // Report whether the op index has a halfword mapping.
    always_comb begin
        case (idx_i)
            H_MIX_UP, H_MIX_LO, H_PACK_ODD, H_SWAP, H_REP_UP, H_REP_LO: hit_o = 1'b1;
            default: hit_o = 1'b0;
        endcase
    end

    for (genvar g = 0; g < LANES_H; g++) begin : g_lane
        lane_route_t rt;

        // Look up the route for this lane.
        assign rt = half_route(idx_i, g);

        // Select the lane payload from the routed source.
        always_comb begin
            case (rt.src)
                SRC_VS:  res_o[HALF_W*g +: HALF_W] = vs_i[HALF_W*rt.elem +: HALF_W];
                SRC_VT:  res_o[HALF_W*g +: HALF_W] = vt_i[HALF_W*rt.elem +: HALF_W];
                default: res_o[HALF_W*g +: HALF_W] = '0;
            endcase
        end
    end

endmodule

// File: rtl/lane_shuffle_unit.sv
// Module lane_shuffle_unit
// Top of the packed lane shuffle unit. Purely combinational: decodes
// the opcode, runs both format paths, and forwards the one the format
// selects. Unmapped opcodes give a zero result and raise invalid_o.
module lane_shuffle_unit
    import lane_shuffle_pkg::*;
(
    input  logic [4:0]  op_i,
    input  logic [63:0] vs_i,
    input  logic [63:0] vt_i,
    output logic [63:0] result_o,
    output logic        invalid_o
);

    lane_fmt_e         fmt;
    logic [BIDX_W-1:0] bidx;
    logic [HIDX_W-1:0] hidx;
    logic [DATA_W-1:0] byte_res;
    logic [DATA_W-1:0] half_res;
    logic              byte_hit;
    logic              half_hit;

    lane_shuffle_decode u_dec (
        .op_i   (op_i),
        .fmt_o  (fmt),
        .bidx_o (bidx),
        .hidx_o (hidx)
    );

    lane_shuffle_byte u_byte (
        .idx_i (bidx),
        .vs_i  (vs_i),
        .vt_i  (vt_i),
        .res_o (byte_res),
        .hit_o (byte_hit)
    );

    lane_shuffle_half u_half (
        .idx_i (hidx),
        .vs_i  (vs_i),
        .vt_i  (vt_i),
        .res_o (half_res),
        .hit_o (half_hit)
    );

    // Choose the path that matches the format and flag unmapped codes.
    always_comb begin
        result_o  = '0;
        invalid_o = 1'b1;
        if (fmt == FMT_BYTE && byte_hit) begin
            result_o  = byte_res;
            invalid_o = 1'b0;
        end else if (fmt == FMT_HALF && half_hit) begin
            result_o  = half_res;
            invalid_o = 1'b0;
        end
    end

endmodule

// File: rtl/lane_shuffle_unit_chk.sv
// Module lane_shuffle_unit_chk
// Checker bound to lane_shuffle_unit. The unit has no clock, so the
// checks are immediate assertions evaluated whenever ports change.
module lane_shuffle_unit_chk (
    input logic [4:0]  op_i,
    input logic [63:0] vs_i,
    input logic [63:0] vt_i,
    input logic [63:0] result_o,
    input logic        invalid_o
);

    // Evaluate port relations whenever any port moves.
    always_comb begin
        // R9
        invalid_zero_chk: assert (!invalid_o || result_o == 64'd0);
        // R1
        fmt_reserved_chk: assert (op_i[1:0] != 2'b11 || invalid_o);
        // R4
        sign_fill_chk: assert (op_i != 5'd4 || result_o[15:8] == {8{vs_i[7]}});
        // R2
        pack_odd_chk: assert (op_i != 5'd6 || result_o[7:0] == vt_i[15:8]);
        // R3
        mix_low_chk: assert (op_i != 5'd12 || result_o[15:8] == vs_i[7:0]);
        // R7
        swap_chk: assert (op_i != 5'd17 || result_o[31:16] == vs_i[15:0]);
        // R8
        rep_up_chk: assert (op_i != 5'd21 || result_o[63:32] == vs_i[63:32]);
    end

endmodule

bind lane_shuffle_unit lane_shuffle_unit_chk chk_i (.*);

// File: tb/lane_shuffle_unit_tb_top.sv
// Directed bench for lane_shuffle_unit: one task per scenario.
module lane_shuffle_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic [4:0]  op;
    logic [63:0] vs;
    logic [63:0] vt;
    logic [63:0] result;
    logic        invalid;
    int          n_checks = 0;
    int          n_errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lane_shuffle_unit dut_i (
        .op_i      (op),
        .vs_i      (vs),
        .vt_i      (vt),
        .result_o  (result),
        .invalid_o (invalid)
    );

    function automatic logic [7:0] bt(input logic [63:0] v, input int i);
        return v[8*i +: 8];
    endfunction

    function automatic logic [15:0] hw(input logic [63:0] v, input int i);
        return v[16*i +: 16];
    endfunction

    function automatic logic [7:0] fill(input logic [7:0] x);
        return x[7] ? 8'hFF : 8'h00;
    endfunction

    task automatic apply(input logic [4:0] o, input logic [63:0] s, input logic [63:0] t);
        @(posedge clk);
        #1;
        op = o; vs = s; vt = t;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h (op=%0d)", req, act, exp, op);
        end
    endtask

    task automatic t_initial;
        // opcode 0 is unmapped byte index 0
        apply(5'd0, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210);
        check("R9 initial result", result, 64'd0);
        check("R9 initial invalid", {63'd0, invalid}, 64'd1);
    endtask

    task automatic t_byte_pack(input logic [63:0] s, input logic [63:0] t);
        apply(5'd6, s, t);
        check("R2 pack odd", result,
              {bt(s,7), bt(s,5), bt(s,3), bt(s,1), bt(t,7), bt(t,5), bt(t,3), bt(t,1)});
        check("R2 pack odd valid", {63'd0, invalid}, 64'd0);
        apply(5'd8, s, t);
        check("R2 pack even", result,
              {bt(s,6), bt(s,4), bt(s,2), bt(s,0), bt(t,6), bt(t,4), bt(t,2), bt(t,0)});
    endtask

    task automatic t_byte_mix(input logic [63:0] s, input logic [63:0] t);
        apply(5'd10, s, t);
        check("R3 mix upper", result,
              {bt(s,7), bt(t,7), bt(s,6), bt(t,6), bt(s,5), bt(t,5), bt(s,4), bt(t,4)});
        apply(5'd12, s, t);
        check("R3 mix lower", result,
              {bt(s,3), bt(t,3), bt(s,2), bt(t,2), bt(s,1), bt(t,1), bt(s,0), bt(t,0)});
    endtask

    task automatic t_byte_widen(input logic [63:0] s, input logic [63:0] t);
        apply(5'd4, s, t);
        check("R4 sign widen", result,
              {fill(bt(s,3)), bt(s,3), fill(bt(s,2)), bt(s,2),
               fill(bt(s,1)), bt(s,1), fill(bt(s,0)), bt(s,0)});
        check("R4 sign widen valid", {63'd0, invalid}, 64'd0);
    endtask

    task automatic t_half_mix(input logic [63:0] s, input logic [63:0] t);
        apply(5'd1, s, t);
        check("R5 half mix upper", result, {hw(s,3), hw(t,3), hw(s,2), hw(t,2)});
        apply(5'd5, s, t);
        check("R5 half mix lower", result, {hw(s,1), hw(t,1), hw(s,0), hw(t,0)});
    endtask

    task automatic t_half_pack(input logic [63:0] s, input logic [63:0] t);
        apply(5'd9, s, t);
        check("R6 half pack odd", result, {hw(s,3), hw(s,1), hw(t,3), hw(t,1)});
        check("R6 half pack valid", {63'd0, invalid}, 64'd0);
    endtask

    task automatic t_swap(input logic [63:0] s, input logic [63:0] t);
        apply(5'd17, s, t);
        check("R7 butterfly", result, {hw(s,2), hw(t,3), hw(s,0), hw(t,1)});
    endtask

    task automatic t_replicate(input logic [63:0] s, input logic [63:0] t);
        apply(5'd21, s, t);
        check("R8 replicate upper", result, {hw(s,3), hw(s,2), hw(t,3), hw(t,2)});
        apply(5'd25, s, t);
        check("R8 replicate lower", result, {hw(s,1), hw(s,0), hw(t,1), hw(t,0)});
    endtask

    task automatic t_unmapped;
        logic [4:0] codes [8] = '{5'd2, 5'd14, 5'd30, 5'd3, 5'd7, 5'd13, 5'd29, 5'd31};
        foreach (codes[k]) begin
            apply(codes[k], 64'hFFFF_FFFF_FFFF_FFFF, 64'hA5A5_A5A5_A5A5_A5A5);
            check("R9 unmapped result", result, 64'd0);
            // R1: codes ending in 11 must flag invalid as well
            check("R1/R9 unmapped invalid", {63'd0, invalid}, 64'd1);
        end
    endtask

    task automatic t_format;
        // R1: same upper bits, format changes the op family
        apply(5'd5, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888);
        check("R1 halfword decode", result, 64'h3333_7777_4444_8888);
        apply(5'd4, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888);
        check("R1 byte decode", result, 64'h0033_0033_0044_0044);
        apply(5'd7, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888);
        check("R1 reserved format", {63'd0, invalid}, 64'd1);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        op = 5'd0; vs = 64'd0; vt = 64'd0;
        t_initial();
        t_byte_pack(64'h1716_1514_1312_1110, 64'h2726_2524_2322_2120);
        t_byte_pack(64'hF0E1_D2C3_B4A5_9687, 64'h0F1E_2D3C_4B5A_6978);
        t_byte_mix(64'h1716_1514_1312_1110, 64'h2726_2524_2322_2120);
        t_byte_mix(64'hDEAD_BEEF_CAFE_F00D, 64'h0123_4567_89AB_CDEF);
        t_byte_widen(64'h1122_3344_80_7F_FF_01, 64'h0);
        t_byte_widen(64'h0000_0000_7F80_01FE, 64'hFFFF_FFFF_FFFF_FFFF);
        t_half_mix(64'h1716_1514_1312_1110, 64'h2726_2524_2322_2120);
        t_half_mix(64'h8000_7FFF_FFFF_0001, 64'hAAAA_5555_CCCC_3333);
        t_half_pack(64'h1716_1514_1312_1110, 64'h2726_2524_2322_2120);
        t_swap(64'h1716_1514_1312_1110, 64'h2726_2524_2322_2120);
        t_swap(64'h8000_7FFF_FFFF_0001, 64'hAAAA_5555_CCCC_3333);
        t_replicate(64'h1716_1514_1312_1110, 64'h2726_2524_2322_2120);
        t_unmapped();
        t_format();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule